// File: doc/BRIEF.md
# Paged-Write Register Target on a Two-Wire Bus

This block is a two-wire serial bus target that sits in front of two byte-addressed register memories, an auxiliary bank and a main bank. It samples the bus clock and data lines on the system clock and recognises START and STOP conditions. It decodes the 7-bit device address to pick a bank and then takes the next byte as the memory pointer. Write data collects in an 8-byte row buffer. The target writes that buffer into the bank only when the STOP arrives. After the commit it stays busy for a fixed number of system clocks.

While it is busy the target leaves its device address unacknowledged, so a host can poll it: the host re-addresses the target until it answers. A read uses a pointer-setting write, a repeated START and the device address with the read bit set. The target then returns bytes MSB first for as long as the host acknowledges them. The data line is only ever pulled low, through an output enable.

This is a control-path block. The bus is its data interface, so there is no valid/ready edge to apply back-pressure. The host paces every byte through the bus clock, and the target never stretches that clock.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the data-line pull-down `sda_oe` and `busy` are both low, and every byte of both banks reads 00h.
- R2: With `addr_sel` low, device address byte A0h/A1h selects the auxiliary bank and A2h/A3h selects the main bank. The target leaves any other device address unacknowledged, for example A4h.
- R3: With `addr_sel` high, the main bank answers at the 7-bit address `main_dev_addr`, shifted left one place with the R/W bit below it, and A2h is no longer acknowledged. The auxiliary bank stays at A0h, but it stops answering when `main_dev_addr` equals 50h, and A0h then reaches the main bank.
- R4: In a write, the target acknowledges the device address byte, then loads the byte that follows into the memory pointer and acknowledges it. It acknowledges every data byte after that.
- R5: Each data byte of a write goes to the pointer's row. The pointer's low 3 bits advance modulo 8 and its upper bits never change. Bytes 11h, 22h and 33h written from 06h land at 06h, 07h and 00h. A ninth byte overwrites the first address of the transaction.
- R6: Write data reaches a bank only at STOP. A repeated START before STOP throws away the buffered bytes, and `busy` stays low.
- R7: A STOP that ends a write carrying at least one data byte raises `busy` on the next clock. `busy` then stays high for exactly WR_CYCLES clocks. No device address is acknowledged while `busy` is high.
- R8: After a repeated START and a device address with R/W=1, the target shifts out the byte at the pointer, MSB first.
- R9: A host ACK after a read byte returns the next byte. The read pointer wraps across the whole 8-bit space, so FFh is followed by 00h. A host NACK ends the read.
- R10: `sda_oe` never changes while the synchronised clock line stays high, and it is low whenever the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low |
| addr_sel | input | 1 | Selects the programmable main-bank address |
| main_dev_addr | input | 7 | Programmed 7-bit main-bank device address |
| busy | output | 1 | High during the post-STOP commit window |

## Verification
The bus lines pass through two synchroniser flops and one edge register, so an acknowledge or data bit appears on `sda_oe` about three clocks after the host lowers the bus clock. The bench holds each bus phase for eight clocks and samples the data line at the middle of the clock-high phase, well clear of that latency. `busy` rises one clock after the STOP is detected. A counter in the bench adds up the high cycles of `busy` and compares the total with WR_CYCLES once `busy` drops. Every data byte read back is queued against a bench model of both banks, and the model applies the row-wrap and pointer-wrap rules on its own.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} tgt_st_e;
  typedef enum logic [1:0] {K_DEV, K_PTR, K_WDATA, K_READ} tgt_kind_e;
  localparam logic [6:0] AUX_DEV      = 7'h50;
  localparam logic [6:0] MAIN_DEV_DEF = 7'h51;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = scl_q & ~scl_sh[STAGES];
  assign scl_fall = ~scl_q & scl_sh[STAGES];
  assign start_p  = scl_q & scl_sh[STAGES] & sda_sh[STAGES] & ~sda_q;
  assign stop_p   = scl_q & scl_sh[STAGES] & ~sda_sh[STAGES] & sda_q;
endmodule

// File: rtl/i2c_tgt_mem.sv
module i2c_tgt_mem #(
  parameter int AW        = 8,
  parameter int ROW_BYTES = 8,
  localparam int RW       = $clog2(ROW_BYTES),
  localparam int DEPTH    = 1 << AW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [AW-RW-1:0]          row,
  input  logic [ROW_BYTES-1:0][7:0] wdata,
  input  logic [ROW_BYTES-1:0]      wmask,
  input  logic [AW-1:0]             raddr,
  output logic [7:0]                rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '{default: '0};
    end else if (commit) begin
      for (int i = 0; i < ROW_BYTES; i++) begin
        if (wmask[i]) mem[{row, RW'(i)}] <= wdata[i];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_tgt_wtimer.sv
module i2c_tgt_wtimer #(
  parameter int WR_CYCLES = 1000,
  localparam int CW       = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (kick)     cnt <= CW'(WR_CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int AW          = 8,
  parameter int ROW_BYTES   = 8,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  input  logic [6:0] main_dev_addr,
  output logic       busy
);
  localparam int RW = $clog2(ROW_BYTES);

  logic scl_q, sda_q, scl_rise, scl_fall, start_p, stop_p;
  tgt_st_e   st;
  tgt_kind_e kind;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [6:0] txsh;
  logic byte_done, tgt_main, rd, mack, oe;
  logic [AW-1:0] ptr;
  logic [ROW_BYTES-1:0][7:0] rowbuf;
  logic [ROW_BYTES-1:0] rmask;
  logic [7:0] rd_m [2];
  logic [7:0] rd_byte;
  logic [6:0] main_sel;
  logic main_hit, aux_hit, commit;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  assign commit = stop_p && (rmask != '0);

  i2c_tgt_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    i2c_tgt_mem #(.AW(AW), .ROW_BYTES(ROW_BYTES)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .commit(commit && (tgt_main == g[0])),
      .row(ptr[AW-1:RW]), .wdata(rowbuf), .wmask(rmask),
      .raddr(ptr), .rdata(rd_m[g])
    );
  end

  assign rd_byte  = rd_m[tgt_main];
  assign main_sel = addr_sel ? main_dev_addr : MAIN_DEV_DEF;
  assign main_hit = (sh[7:1] == main_sel);
  assign aux_hit  = (sh[7:1] == AUX_DEV) && (main_sel != AUX_DEV);
  assign sda_oe   = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  kind <= K_DEV;  cnt <= '0;  sh <= '0;  txsh <= '0;
      byte_done <= 1'b0;  tgt_main <= 1'b0;  rd <= 1'b0;  mack <= 1'b0;
      oe <= 1'b0;  ptr <= '0;  rowbuf <= '0;  rmask <= '0;
    end else if (start_p) begin
      st <= ST_RX;  kind <= K_DEV;  cnt <= '0;  byte_done <= 1'b0;
      oe <= 1'b0;  rmask <= '0;
    end else if (stop_p) begin
      st <= ST_IDLE;  oe <= 1'b0;  rmask <= '0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            case (kind)
              K_DEV: begin
                if ((main_hit || aux_hit) && !busy) begin
                  oe <= 1'b1;  st <= ST_ACK;  tgt_main <= main_hit;  rd <= sh[0];
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_PTR: begin
                ptr <= sh[AW-1:0];  oe <= 1'b1;  st <= ST_ACK;
              end
              default: begin
                rowbuf[ptr[RW-1:0]] <= sh;
                rmask[ptr[RW-1:0]]  <= 1'b1;
                ptr <= {ptr[AW-1:RW], ptr[RW-1:0] + RW'(1)};
                oe  <= 1'b1;  st <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (kind == K_DEV && rd) begin
              st <= ST_TX;  kind <= K_READ;
              txsh <= rd_byte[6:0];  oe <= ~rd_byte[7];
            end else begin
              oe <= 1'b0;  st <= ST_RX;
              kind <= (kind == K_DEV) ? K_PTR : K_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              oe <= 1'b0;  st <= ST_MACK;
            end else begin
              cnt  <= cnt + 1'b1;
              oe   <= ~txsh[6];
              txsh <= {txsh[5:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_q;
            if (!sda_q) ptr <= ptr + 1'b1;
          end else if (scl_fall) begin
            if (mack) begin
              st <= ST_TX;  cnt <= '0;
              txsh <= rd_byte[6:0];  oe <= ~rd_byte[7];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 8,
  parameter int ROW_BYTES = 8,
  localparam int RW = $clog2(ROW_BYTES)
) (
  input logic      clk,
  input logic      rst_n,
  input logic      scl_q,
  input logic      stop_p,
  input logic      sda_oe,
  input logic      busy,
  input tgt_st_e   st,
  input tgt_kind_e kind,
  input logic [AW-1:0] ptr
);
  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R10
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_ACK && kind == K_DEV) |-> !sda_oe); // R7
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_p)); // R7
  AST_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_WDATA && $past(kind) == K_WDATA) |-> (ptr[AW-1:RW] == $past(ptr[AW-1:RW]))); // R5
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW), .ROW_BYTES(ROW_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_p(stop_p), .sda_oe(sda_oe),
  .busy(busy), .st(st), .kind(kind), .ptr(ptr)
);

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int WR_CYC = 600;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [6:0] main_dev_addr = 7'h00;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_mem_target #(.WR_CYCLES(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .main_dev_addr(main_dev_addr), .busy(busy)
  );

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] mdl [2][256];
  logic [7:0] wdat [16];
  int tests = 0, fails = 0, busy_cyc = 0;
  bit done = 0;

  always @(posedge clk) if (busy) busy_cyc <= busy_cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected queue as bytes arrive from the bus
  initial forever begin
    wait (got_q.size() > 0);
    begin
      logic [7:0] g;
      item_t e;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      chk(g == e.v, e.tag, g, e.v);
    end
  end

  task automatic hold(); repeat (Q) @(negedge clk); endtask
  task automatic bstart();  sda_m = 1; scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold(); endtask
  task automatic brstart(); sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold(); endtask
  task automatic bstop();   sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold(); endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1; hold(); scl_m = 0; hold();
    end
    sda_m = 1; hold(); scl_m = 1;
    repeat (Q/2) @(negedge clk);
    ack = ~sda_line;
    repeat (Q/2) @(negedge clk);
    scl_m = 0; hold();
  endtask

  task automatic rb(input bit host_ack);
    logic [7:0] b;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1; repeat (Q/2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q/2) @(negedge clk); scl_m = 0; hold();
    end
    got_q.push_back(b);
    sda_m = host_ack ? 1'b0 : 1'b1; hold(); scl_m = 1; hold(); scl_m = 0; hold(); sda_m = 1;
  endtask

  task automatic wait_idle(); while (busy) @(negedge clk); hold(); endtask

  // full write; model applies the row wrap of R5
  task automatic wr(input logic [7:0] dev, input int bank, input logic [7:0] a, input int n, input string tag);
    bit ack;
    bstart();
    wb(dev, ack);  chk(ack, {tag, " R4 dev ack"}, ack, 1);
    wb(a, ack);    chk(ack, {tag, " R4 ptr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      wb(wdat[i], ack); chk(ack, {tag, " R4 data ack"}, ack, 1);
      mdl[bank][{a[7:3], 3'(a[2:0] + i)}] = wdat[i];
    end
    bstop();
    wait_idle();
  endtask

  task automatic rd(input logic [7:0] dev, input int bank, input logic [7:0] a, input int n, input string tag);
    bit ack;
    bstart();
    wb(dev, ack);  chk(ack, {tag, " dev ack"}, ack, 1);
    wb(a, ack);    chk(ack, {tag, " ptr ack"}, ack, 1);
    brstart();
    wb(dev | 8'h01, ack); chk(ack, {tag, " R8 read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{mdl[bank][8'(a + i)], tag});
      rb(i < n - 1);
    end
    bstop();
    wait (got_q.size() == 0);
  endtask

  task automatic addr_only(input logic [7:0] dev, output bit ack);
    bstart(); wb(dev, ack); bstop();
  endtask

  initial begin
    repeat (QQ0) @(negedge clk);
  end
  localparam int QQ0 = 1;

  initial begin
    bit ack;
    int nacks;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) mdl[b][i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 0, "R1 sda_oe after reset", sda_oe, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    rd(8'hA2, 1, 8'h05, 2, "R1 main reads zero");

    // single byte write and acknowledge polling
    wdat[0] = 8'h00; wdat[0] = 8'h5C;
    busy_cyc = 0;
    bstart(); wb(8'hA2, ack); wb(8'hBA, ack); wb(wdat[0], ack); bstop();
    mdl[1][8'hBA] = 8'h5C;
    nacks = 0;
    ack = 0;
    while (!ack) begin
      addr_only(8'hA2, ack);
      if (!ack) nacks++;
    end
    chk(nacks >= 1, "R7 no ack while busy", nacks, 1);
    wait_idle();
    chk(busy_cyc == WR_CYC, "R7 busy length", busy_cyc, WR_CYC);
    rd(8'hA2, 1, 8'hBA, 1, "R8 random read");

    // row wrap: 06h, 07h, 00h
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    wr(8'hA2, 1, 8'h06, 3, "R5 3-byte");
    rd(8'hA2, 1, 8'h00, 8, "R5 row readback");
    for (int i = 0; i < 9; i++) wdat[i] = 8'h40 + 8'(i);
    wr(8'hA2, 1, 8'h10, 9, "R5 9-byte");
    rd(8'hA2, 1, 8'h10, 8, "R5 ninth overwrote");

    // aux bank is separate, other addresses refused
    wdat[0] = 8'hA5; wdat[1] = 8'h3C;
    wr(8'hA0, 0, 8'h10, 2, "R2 aux write");
    rd(8'hA0, 0, 8'h10, 2, "R2 aux read");
    rd(8'hA2, 1, 8'h10, 2, "R2 main unchanged");
    addr_only(8'hA4, ack); chk(!ack, "R2 A4h refused", ack, 0);

    // abort by repeated START
    bstart(); wb(8'hA2, ack); wb(8'h40, ack); wb(8'h77, ack);
    brstart(); wb(8'hA3, ack);
    exp_q.push_back('{mdl[1][8'h40], "R6 abort kept old"});
    rb(0); bstop();
    wait (got_q.size() == 0);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R6 no busy after abort", busy, 0);

    // read pointer wraps across full space
    wdat[0] = 8'hE1; wdat[1] = 8'hF2;
    wr(8'hA2, 1, 8'hFE, 2, "R9 setup");
    rd(8'hA2, 1, 8'hFE, 4, "R9 8-bit wrap");

    // programmable main address
    addr_sel = 1; main_dev_addr = 7'h58;
    addr_only(8'hA2, ack); chk(!ack, "R3 A2h refused", ack, 0);
    wdat[0] = 8'h9D;
    wr(8'hB0, 1, 8'h20, 1, "R3 B0h main");
    rd(8'hB0, 1, 8'h20, 1, "R3 B0h read");
    rd(8'hA0, 0, 8'h10, 1, "R3 aux still A0h");
    main_dev_addr = 7'h50;
    wdat[0] = 8'h5A;
    wr(8'hA0, 1, 8'h30, 1, "R3 A0h to main");
    addr_sel = 0;
    rd(8'hA0, 0, 8'h30, 1, "R3 aux untouched");
    rd(8'hA2, 1, 8'h30, 1, "R3 main got it");
    chk(sda_oe == 0, "R10 released at end", sda_oe, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule